// File: doc/BRIEF.md
# Profile-Pin Modulation Selector

This block turns four externally timed selection pins into a modulation control for one synthesis channel. A table of profile words is loaded through a simple write port. The pins are brought into the sync-clock domain and then used as an index into that table. The chosen word drives the channel's frequency tuning word, phase offset or amplitude scale, so the pins can key 2, 4, 8 or 16 levels of FSK, PSK or ASK. The two quantities that are not modulated keep their base register values.

A 3-bit pin-function field picks how many pins form the index. The same field can also select a ramp mode. In ramp mode, pin 0 sets the direction of a linear sweep accumulator that steps by a programmed amount on every sync clock cycle and saturates at programmed lower and upper limits. A 2-bit modulation-kind field picks which output the table or the sweep drives, or turns modulation off.

Top module: `profile_mod_sel`

## Requirements
- R1: While `rst_n` is low, `ftw_out`, `pow_out` and `asf_out` are zero, and every stored word is cleared.
- R2: With `pin_fn` = 000, the index is `prof_pins` read as a binary number with pin 0 as the least significant bit. Index 0 selects the base word of the modulated quantity, and index n (1..15) selects the profile word written at address n.
- R3: A change on `prof_pins` shows on the outputs after the third rising `clk` edge that follows it, and not after the second.
- R4: With `mod_kind` = 00 (frequency), `ftw_out` carries the selected word, while `pow_out` and `asf_out` carry the base phase and base amplitude words.
- R5: With `mod_kind` = 01 (phase), `pow_out` carries the low 14 bits of the selected word, while `ftw_out` and `asf_out` carry their base words.
- R6: With `mod_kind` = 10 (amplitude), `asf_out` carries the low 10 bits of the selected word, while `ftw_out` and `pow_out` carry their base words.
- R7: With `mod_kind` = 11, all three outputs carry their base words and the pins have no effect.
- R8: `pin_fn` = 001, 010 and 011 build the index from pin 0 only, from pins 1:0, and from pins 2:0 respectively. The other pins read as zero.
- R9: With `pin_fn` = 100, a high pin 0 raises the sweep value by the step word on every cycle, up to the upper limit. A low pin 0 lowers it by the step word down to the lower limit. Pins 3:1 have no effect, and the sweep value drives the modulated quantity.
- R10: The sweep saturates at its limits without wrapping, even where adding the step would pass 2^32 or subtracting it would go below zero.
- R11: `pin_fn` values 101, 110 and 111 behave as 000.
- R12: Address map: 1..15 hold profile words, 16 base frequency, 17 base phase (low 14 bits), 18 base amplitude (low 10 bits), 19 sweep step, 20 upper limit, 21 lower limit. Writes to any other address, including 0, change nothing.
- R13: Outside ramp mode, the sweep value is held at the lower limit, so each ramp starts from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the word store |
| wr_addr | input | 5 | Write address (see R12) |
| wr_data | input | 32 | Write data |
| prof_pins | input | 4 | Asynchronous profile selection pins |
| pin_fn | input | 3 | Pin-function field |
| mod_kind | input | 2 | Modulated quantity: 00 freq, 01 phase, 10 amplitude, 11 none |
| ftw_out | output | 32 | Active frequency tuning word |
| pow_out | output | 14 | Active phase offset word |
| asf_out | output | 10 | Active amplitude scale word |

## Verification
A wrong synchronizer stage shows up as an output that moves one edge early or late after a pin change, and the latency checks measure exactly that. A corrupted table entry or a bad index mask appears on the next sample as the wrong word on the modulated output. A broken sweep accumulator shows up within a few cycles of a pin-0 transition: the steps are missing, the value overshoots a limit, or it wraps around. A fault in the preset is visible as soon as ramp mode is entered, because the output does not start at the lower limit.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    FN_LVL16 = 3'd0,
    FN_LVL2  = 3'd1,
    FN_LVL4  = 3'd2,
    FN_LVL8  = 3'd3,
    FN_SWEEP = 3'd4
  } pin_fn_e;

  typedef enum logic [1:0] {
    MK_FREQ  = 2'd0,
    MK_PHASE = 2'd1,
    MK_AMP   = 2'd2,
    MK_OFF   = 2'd3
  } mod_kind_e;

  // Unused codes collapse onto the full-width direct select.
  function automatic pin_fn_e decode_fn(input logic [2:0] code);
    case (code)
      3'd1:    decode_fn = FN_LVL2;
      3'd2:    decode_fn = FN_LVL4;
      3'd3:    decode_fn = FN_LVL8;
      3'd4:    decode_fn = FN_SWEEP;
      default: decode_fn = FN_LVL16;
    endcase
  endfunction

endpackage

// File: rtl/pms_pin_sync.sv
module pms_pin_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/pms_regfile.sv
module pms_regfile #(
  parameter  int PINS    = 4,
  parameter  int WORD_W  = 32,
  parameter  int PHASE_W = 14,
  parameter  int AMP_W   = 10,
  localparam int ENTRIES = 2 ** PINS,
  localparam int ADDR_W  = $clog2(ENTRIES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [PINS-1:0]    rd_idx,
  output logic [WORD_W-1:0]  rd_word,
  output logic [WORD_W-1:0]  base_ftw,
  output logic [PHASE_W-1:0] base_pow,
  output logic [AMP_W-1:0]   base_asf,
  output logic [WORD_W-1:0]  sw_step,
  output logic [WORD_W-1:0]  sw_hi,
  output logic [WORD_W-1:0]  sw_lo
);

  localparam int A_BFTW = ENTRIES;
  localparam int A_BPOW = ENTRIES + 1;
  localparam int A_BASF = ENTRIES + 2;
  localparam int A_STEP = ENTRIES + 3;
  localparam int A_HI   = ENTRIES + 4;
  localparam int A_LO   = ENTRIES + 5;

  logic [ENTRIES-1:1] prof_we;
  logic               bftw_we, bpow_we, basf_we, step_we, hi_we, lo_we;
  logic [WORD_W-1:0]  prof_q [1:ENTRIES-1];

  // Write decode (next-state side)
  always_comb begin
    for (int i = 1; i < ENTRIES; i++) begin
      prof_we[i] = wr_en && (wr_addr == ADDR_W'(i));
    end
    bftw_we = wr_en && (wr_addr == ADDR_W'(A_BFTW));
    bpow_we = wr_en && (wr_addr == ADDR_W'(A_BPOW));
    basf_we = wr_en && (wr_addr == ADDR_W'(A_BASF));
    step_we = wr_en && (wr_addr == ADDR_W'(A_STEP));
    hi_we   = wr_en && (wr_addr == ADDR_W'(A_HI));
    lo_we   = wr_en && (wr_addr == ADDR_W'(A_LO));
  end

  for (genvar g = 1; g < ENTRIES; g++) begin : g_prof
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prof_q[g] <= '0;
      end else if (prof_we[g]) begin
        prof_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_ftw <= '0;
      base_pow <= '0;
      base_asf <= '0;
      sw_step  <= '0;
      sw_hi    <= '0;
      sw_lo    <= '0;
    end else begin
      if (bftw_we) base_ftw <= wr_data;
      if (bpow_we) base_pow <= wr_data[PHASE_W-1:0];
      if (basf_we) base_asf <= wr_data[AMP_W-1:0];
      if (step_we) sw_step  <= wr_data;
      if (hi_we)   sw_hi    <= wr_data;
      if (lo_we)   sw_lo    <= wr_data;
    end
  end

  // Entry 0 is supplied by the caller from the base words.
  always_comb begin
    rd_word = '0;
    if (rd_idx != '0) begin
      rd_word = prof_q[rd_idx];
    end
  end

endmodule

// File: rtl/pms_sweep.sv
module pms_sweep #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         up,
  input  logic [W-1:0] step,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic [W-1:0] acc_q
);

  logic [W:0]   sum_w;
  logic [W:0]   diff_w;
  logic [W-1:0] acc_d;

  always_comb begin
    sum_w  = {1'b0, acc_q} + {1'b0, step};
    diff_w = {1'b0, acc_q} - {1'b0, step};
    if (!en) begin
      acc_d = lo;
    end else if (up) begin
      acc_d = (sum_w >= {1'b0, hi}) ? hi : sum_w[W-1:0];
    end else begin
      acc_d = (diff_w[W] || (diff_w[W-1:0] <= lo)) ? lo : diff_w[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/profile_mod_sel.sv
module profile_mod_sel
  import pms_pkg::*;
#(
  parameter  int PINS    = 4,
  parameter  int WORD_W  = 32,
  parameter  int PHASE_W = 14,
  parameter  int AMP_W   = 10,
  localparam int ENTRIES = 2 ** PINS,
  localparam int ADDR_W  = $clog2(ENTRIES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [PINS-1:0]    prof_pins,
  input  logic [2:0]         pin_fn,
  input  logic [1:0]         mod_kind,
  output logic [WORD_W-1:0]  ftw_out,
  output logic [PHASE_W-1:0] pow_out,
  output logic [AMP_W-1:0]   asf_out
);

  logic [PINS-1:0]    pin_q;
  logic [PINS-1:0]    idx;
  pin_fn_e            fn;
  int                 lvl_bits;
  logic               sweep_en;
  logic               sweep_up;
  logic [WORD_W-1:0]  rd_word;
  logic [WORD_W-1:0]  base_ftw;
  logic [PHASE_W-1:0] base_pow;
  logic [AMP_W-1:0]   base_asf;
  logic [WORD_W-1:0]  sw_step, lim_hi, lim_lo;
  logic [WORD_W-1:0]  sweep_acc;
  logic [WORD_W-1:0]  base_sel;
  logic [WORD_W-1:0]  sel_word;
  logic [WORD_W-1:0]  mod_src;
  logic [WORD_W-1:0]  ftw_d;
  logic [PHASE_W-1:0] pow_d;
  logic [AMP_W-1:0]   asf_d;

  pms_pin_sync #(.W(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (prof_pins),
    .q     (pin_q)
  );

  pms_regfile #(
    .PINS(PINS), .WORD_W(WORD_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_idx   (idx),
    .rd_word  (rd_word),
    .base_ftw (base_ftw),
    .base_pow (base_pow),
    .base_asf (base_asf),
    .sw_step  (sw_step),
    .sw_hi    (lim_hi),
    .sw_lo    (lim_lo)
  );

  pms_sweep #(.W(WORD_W)) u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sweep_en),
    .up    (sweep_up),
    .step  (sw_step),
    .hi    (lim_hi),
    .lo    (lim_lo),
    .acc_q (sweep_acc)
  );

  // Pin function and index masking
  always_comb begin
    fn       = decode_fn(pin_fn);
    sweep_en = (fn == FN_SWEEP);
    sweep_up = pin_q[0];
    case (fn)
      FN_LVL2: lvl_bits = 1;
      FN_LVL4: lvl_bits = 2;
      FN_LVL8: lvl_bits = 3;
      default: lvl_bits = PINS;
    endcase
    for (int b = 0; b < PINS; b++) begin
      idx[b] = pin_q[b] && (b < lvl_bits);
    end
  end

  // Word selection and routing to the modulated output
  always_comb begin
    case (mod_kind_e'(mod_kind))
      MK_PHASE: base_sel = WORD_W'(base_pow);
      MK_AMP:   base_sel = WORD_W'(base_asf);
      default:  base_sel = base_ftw;
    endcase
    sel_word = (idx == '0) ? base_sel : rd_word;
    mod_src  = sweep_en ? sweep_acc : sel_word;
    ftw_d    = base_ftw;
    pow_d    = base_pow;
    asf_d    = base_asf;
    case (mod_kind_e'(mod_kind))
      MK_FREQ:  ftw_d = mod_src;
      MK_PHASE: pow_d = mod_src[PHASE_W-1:0];
      MK_AMP:   asf_d = mod_src[AMP_W-1:0];
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_out <= '0;
      pow_out <= '0;
      asf_out <= '0;
    end else begin
      ftw_out <= ftw_d;
      pow_out <= pow_d;
      asf_out <= asf_d;
    end
  end

endmodule

// File: rtl/profile_mod_sel_chk.sv
module profile_mod_sel_chk #(
  parameter int PINS   = 4,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PINS-1:0]   prof_pins,
  input logic [PINS-1:0]   pin_q,
  input logic              sweep_en,
  input logic              sweep_up,
  input logic [WORD_W-1:0] acc,
  input logic [WORD_W-1:0] lim_hi,
  input logic [WORD_W-1:0] lim_lo,
  input logic [1:0]        mod_kind,
  input logic [WORD_W-1:0] base_ftw,
  input logic [WORD_W-1:0] ftw_out
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  // R3: the index in use is the pin value from two edges back
  a_r3_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (pin_q == $past(prof_pins, 2)));

  // R13: outside ramp mode the sweep value tracks the lower limit
  a_r13_preset_low: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !sweep_en) |=> (acc == $past(lim_lo)));

  // R9, R10: rising ramp never drops and never passes the upper limit
  a_r9_rise_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && $past(sweep_en && sweep_up) && ($past(acc) <= $past(lim_hi)))
    |-> (acc >= $past(acc) && acc <= $past(lim_hi)));

  // R9, R10: falling ramp never rises and never passes the lower limit
  a_r10_fall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && $past(sweep_en && !sweep_up) && ($past(acc) >= $past(lim_lo)))
    |-> (acc <= $past(acc) && acc >= $past(lim_lo)));

  // R7: modulation off leaves the frequency output on its base word
  a_r7_off_base: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && $past(mod_kind) == 2'd3) |-> (ftw_out == $past(base_ftw)));

endmodule

bind profile_mod_sel profile_mod_sel_chk #(.PINS(PINS), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prof_pins (prof_pins),
  .pin_q     (pin_q),
  .sweep_en  (sweep_en),
  .sweep_up  (sweep_up),
  .acc       (sweep_acc),
  .lim_hi    (lim_hi),
  .lim_lo    (lim_lo),
  .mod_kind  (mod_kind),
  .base_ftw  (base_ftw),
  .ftw_out   (ftw_out)
);

// File: tb/profile_mod_sel_tb.sv
module profile_mod_sel_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  prof_pins;
  logic [2:0]  pin_fn;
  logic [1:0]  mod_kind;
  logic [31:0] ftw_out;
  logic [13:0] pow_out;
  logic [9:0]  asf_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [31:0] B_FTW = 32'hA5A5_0001;
  localparam logic [13:0] B_POW = 14'h1234;
  localparam logic [9:0]  B_ASF = 10'h155;

  profile_mod_sel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prof_pins(prof_pins), .pin_fn(pin_fn), .mod_kind(mod_kind),
    .ftw_out(ftw_out), .pow_out(pow_out), .asf_out(asf_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] pval(input int k);
    pval = 32'h1357_0000 + 32'(k) * 32'h0011_0203;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic apply(input logic [3:0] p, input logic [2:0] f, input logic [1:0] m);
    @(negedge clk);
    prof_pins = p; pin_fn = f; mod_kind = m;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ftw reset", ftw_out, 32'h0);
    check("R1 pow reset", 32'(pow_out), 32'h0);
    check("R1 asf reset", 32'(asf_out), 32'h0);
  endtask

  task automatic t_load();
    for (int k = 1; k < 16; k++) wr(5'(k), pval(k));
    wr(5'd16, B_FTW);
    wr(5'd17, 32'hFFFF_0000 | 32'(B_POW));
    wr(5'd18, 32'hFFFF_F000 | 32'(B_ASF));
    wr(5'd0, 32'hDEAD_BEEF);   // R12: ignored
    wr(5'd31, 32'hBAD0_BAD0);  // R12: ignored
  endtask

  task automatic t_fsk16();
    for (int k = 0; k < 16; k++) begin
      apply(4'(k), 3'd0, 2'd0);
      check("R2/R4/R12 fsk word", ftw_out, (k == 0) ? B_FTW : pval(k));
      check("R4 pow base", 32'(pow_out), 32'(B_POW));
      check("R4 asf base", 32'(asf_out), 32'(B_ASF));
    end
  endtask

  task automatic t_latency();
    apply(4'd3, 3'd0, 2'd0);
    @(negedge clk);
    prof_pins = 4'd5;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3 old after two edges", ftw_out, pval(3));
    @(posedge clk); @(negedge clk);
    check("R3 new after three edges", ftw_out, pval(5));
  endtask

  task automatic t_psk_ask();
    for (int k = 0; k < 16; k += 5) begin
      apply(4'(k), 3'd0, 2'd1);
      check("R5 psk word", 32'(pow_out), (k == 0) ? 32'(B_POW) : 32'(pval(k) & 32'h3FFF));
      check("R5 ftw base", ftw_out, B_FTW);
      check("R5 asf base", 32'(asf_out), 32'(B_ASF));
      apply(4'(k), 3'd0, 2'd2);
      check("R6 ask word", 32'(asf_out), (k == 0) ? 32'(B_ASF) : 32'(pval(k) & 32'h3FF));
      check("R6 ftw base", ftw_out, B_FTW);
      check("R6 pow base", 32'(pow_out), 32'(B_POW));
    end
  endtask

  task automatic t_off();
    for (int k = 1; k < 16; k += 7) begin
      apply(4'(k), 3'd0, 2'd3);
      check("R7 ftw base", ftw_out, B_FTW);
      check("R7 pow base", 32'(pow_out), 32'(B_POW));
      check("R7 asf base", 32'(asf_out), 32'(B_ASF));
    end
  endtask

  task automatic t_levels();
    apply(4'b1110, 3'd1, 2'd0); check("R8 two-level high pins ignored", ftw_out, B_FTW);
    apply(4'b0011, 3'd1, 2'd0); check("R8 two-level pin0", ftw_out, pval(1));
    apply(4'b1111, 3'd2, 2'd0); check("R8 four-level", ftw_out, pval(3));
    apply(4'b1100, 3'd2, 2'd0); check("R8 four-level masked", ftw_out, B_FTW);
    apply(4'b1111, 3'd3, 2'd0); check("R8 eight-level", ftw_out, pval(7));
    apply(4'b1010, 3'd3, 2'd0); check("R8 eight-level masked", ftw_out, pval(2));
  endtask

  task automatic t_fallback();
    for (int f = 5; f < 8; f++) begin
      apply(4'b1111, 3'(f), 2'd0); check("R11 fallback full", ftw_out, pval(15));
      apply(4'b1001, 3'(f), 2'd0); check("R11 fallback mixed", ftw_out, pval(9));
    end
  endtask

  // Drive pin 0 and compare each change of ftw_out with the expected steps.
  task automatic ramp(input string req, input logic [3:0] p, input int n,
                      input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2);
    logic [31:0] exp_v [3];
    logic [31:0] prev;
    int seen;
    exp_v[0] = e0; exp_v[1] = e1; exp_v[2] = e2;
    seen = 0;
    @(negedge clk);
    prev = ftw_out;
    prof_pins = p;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      if (ftw_out !== prev) begin
        if (seen < n) check(req, ftw_out, exp_v[seen]);
        else check({req, " extra step"}, ftw_out, prev);
        seen++;
        prev = ftw_out;
      end
    end
    check({req, " step count"}, 32'(seen), 32'(n));
    check({req, " final"}, ftw_out, exp_v[n-1]);
  endtask

  task automatic t_sweep();
    apply(4'd0, 3'd0, 2'd0);
    wr(5'd19, 32'd300);
    wr(5'd20, 32'd1000);
    wr(5'd21, 32'd100);
    apply(4'b0000, 3'd4, 2'd0);
    check("R13 starts at lower", ftw_out, 32'd100);
    apply(4'b1110, 3'd4, 2'd0);
    check("R9 pins 3:1 ignored", ftw_out, 32'd100);
    ramp("R9 ramp up", 4'b0001, 3, 32'd400, 32'd700, 32'd1000);
    ramp("R9 ramp down", 4'b1110, 3, 32'd700, 32'd400, 32'd100);
    apply(4'd0, 3'd0, 2'd0);
    wr(5'd21, 32'd200);
    apply(4'd0, 3'd4, 2'd0);
    check("R13 preset follows new lower", ftw_out, 32'd200);
  endtask

  task automatic t_wrap();
    apply(4'd0, 3'd0, 2'd0);
    wr(5'd19, 32'h8000_0000);
    wr(5'd20, 32'hFFFF_FFF0);
    wr(5'd21, 32'h0000_0010);
    apply(4'd0, 3'd4, 2'd0);
    check("R10 start", ftw_out, 32'h10);
    ramp("R10 no overflow wrap", 4'b0001, 2, 32'h8000_0010, 32'hFFFF_FFF0, 32'h0);
    ramp("R10 no underflow wrap", 4'b0000, 2, 32'h7FFF_FFF0, 32'h0000_0010, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    prof_pins = '0; pin_fn = '0; mod_kind = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_load();
    t_fsk16();
    t_latency();
    t_psk_ask();
    t_off();
    t_levels();
    t_fallback();
    t_sweep();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule